// File: doc/BRIEF.md
# Clock Calendar Update Engine

This block keeps the time of day and a hundred-year calendar. An external one-pulse-per-second enable starts each update. The block warns its neighbours with a busy level before the counters advance. After the update it emits a one-cycle completion pulse. The counters live in an internal binary copy. The host never sees that copy directly. It sees a ten-byte buffer that is refreshed at the end of every update.

Through a small register port the host reads and writes the buffer and one control byte. The control byte picks binary or BCD coding, 12- or 24-hour hours, an optional daylight-saving rule, an update-complete interrupt enable and a freeze bit. While the buffer is frozen, the internal counters keep running. Any time bytes the host writes while frozen are loaded into the counters when the freeze is lifted.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset the counters hold 00:00:00, day of week 1, day 1, month 1, year 0, and the control byte reads 0x00 (BCD, 12-hour). The buffer therefore reads seconds 0x00, hours 0x12, day of week 0x01, day 0x01, month 0x01 and year 0x00. The status byte (address 10) reads 0x00.
- R2: A tick seen while idle raises `upd_busy` one cycle later. `upd_busy` then stays high for LEAD_CYC+UPD_CYC cycles. A tick seen while an update is already under way is ignored.
- R3: `upd_done` is high for exactly one cycle, the first cycle after the update sequence ends. In that cycle the buffer already shows the new time. `upd_irq` equals `upd_done` while the interrupt enable (control bit 4) is set, and is 0 otherwise.
- R4: The counters roll over in this chain: seconds at 59, minutes at 59, hours at 23, day of week from 7 back to 1, day at month end, month 12 to 1, and year 99 to 0.
- R5: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of 4 and 28 days otherwise. All other months have 31 days.
- R6: Control bit 2 set selects plain binary for all time and alarm bytes. Control bit 2 clear selects two-digit BCD.
- R7: Control bit 1 set selects 24-hour hours (0–23). Control bit 1 clear selects 12-hour hours (1–12). In 12-hour mode bit 7 of the hour byte flags PM and midnight reads as 12 AM.
- R8: Control bit 7 (freeze) set does four things: the buffer is not refreshed, `upd_busy` stays low, the counters keep advancing on ticks, and writing the control byte with bit 7 set forces the interrupt enable to 0.
- R9: A time-byte write with the freeze bit clear takes effect in the counters at once. With the freeze bit set, written bytes are loaded when the freeze is lifted. Unwritten fields keep their counted value.
- R10: With control bit 0 set, on a Sunday (day of week 1) in month 4 with day ≤ 7, the update from 01:59:59 goes to 03:00:00.
- R11: With control bit 0 set, on a Sunday in month 10 with day ≥ 25, the first update from 01:59:59 goes to 01:00:00. A later pass through 01:59:59 that month continues to 02:00:00.
- R12: The alarm bytes (addresses 1, 3, 5) keep the value the host wrote. Updates never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle once-per-second update request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0–9 buffer, 10 status, 11 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| upd_busy | output | 1 | Update warning / in-progress level |
| upd_done | output | 1 | One-cycle update-complete pulse |
| upd_irq | output | 1 | Update-complete interrupt request |

## Verification
The bench builds the block with LEAD_CYC=3 and UPD_CYC=5. An update sequence therefore lasts eight cycles. This makes it cheap to land a second tick inside a running sequence and to run dozens of updates. The short window keeps every calendar corner within a few ticks: the year end, February in leap and plain years, 30-day months, the 12-hour noon and midnight crossings, and both daylight-saving jumps. The bench reaches each corner by loading the clock just before it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NFIELDS   = 7;
    localparam int NBYTES    = 10;
    localparam int ADDR_W    = 4;
    localparam int ADDR_STAT = 10;
    localparam int ADDR_CTRL = 11;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DOM  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [6:0] field_t;
    typedef field_t [NFIELDS-1:0] tod_t;

    typedef struct packed {
        logic inh;
        logic uie;
        logic bin;
        logic h24;
        logic dst;
    } ctl_t;

    localparam tod_t TOD_RESET = '{7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};

    function automatic logic [3:0] field_addr(input int i);
        case (i)
            F_SEC:   return 4'd0;
            F_MIN:   return 4'd2;
            F_HOUR:  return 4'd4;
            F_DOW:   return 4'd6;
            F_DOM:   return 4'd7;
            F_MON:   return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    function automatic logic [7:0] to_bcd(input field_t v);
        logic [7:0] tens;
        tens = 8'(v) / 8'd10;
        return (tens << 4) + (8'(v) - tens * 8'd10);
    endfunction

    function automatic field_t from_bcd(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] enc_byte(input field_t v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic field_t dec_byte(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : from_bcd(b);
    endfunction

    function automatic logic [7:0] enc_hour(input field_t h, input logic bin, input logic h24);
        logic   pm;
        field_t h12;
        if (h24) return enc_byte(h, bin);
        pm  = (h >= 7'd12);
        h12 = pm ? h - 7'd12 : h;
        if (h12 == 7'd0) h12 = 7'd12;
        return enc_byte(h12, bin) | {pm, 7'b0};
    endfunction

    function automatic field_t dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        field_t h;
        if (h24) return dec_byte(b, bin);
        h = dec_byte({1'b0, b[6:0]}, bin);
        if (h == 7'd12) h = 7'd0;
        if (b[7]) h = h + 7'd12;
        return h;
    endfunction

    function automatic field_t month_days(input field_t mon, input field_t year);
        case (mon)
            7'd2:                      return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic inhibit,
    output logic step,
    output logic xfer,
    output logic busy,
    output logic done
);
    localparam int MAXC  = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef enum logic [1:0] {S_IDLE, S_WARN, S_UPD} seq_state_t;
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    assign step = (state == S_WARN) && (cnt == '0);
    assign xfer = (state == S_UPD)  && (cnt == '0);
    assign busy = (state != S_IDLE) && !inhibit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (tick) begin
                    state <= S_WARN;
                    cnt   <= CNT_W'(LEAD_CYC - 1);
                end
                S_WARN: if (cnt == '0) begin
                    state <= S_UPD;
                    cnt   <= CNT_W'(UPD_CYC - 1);
                end else cnt <= cnt - 1'b1;
                default: if (cnt == '0) begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end else cnt <= cnt - 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               dst_en,
    input  logic [NFIELDS-1:0] ld_mask,
    input  tod_t               ld_val,
    output tod_t               cur
);
    tod_t nxt;
    logic fell, fall_set, fall_clr, at_159, sunday;

    always_comb begin
        nxt      = cur;
        fall_set = 1'b0;
        fall_clr = 1'b0;
        at_159   = (cur[F_HOUR] == 7'd1) && (cur[F_MIN] == 7'd59) && (cur[F_SEC] == 7'd59);
        sunday   = (cur[F_DOW] == 7'd1);
        if (dst_en && at_159 && sunday && cur[F_MON] == 7'd4 && cur[F_DOM] <= 7'd7) begin
            nxt[F_HOUR] = 7'd3;
            nxt[F_MIN]  = 7'd0;
            nxt[F_SEC]  = 7'd0;
        end else if (dst_en && at_159 && sunday && cur[F_MON] == 7'd10 &&
                     cur[F_DOM] >= 7'd25 && !fell) begin
            nxt[F_MIN] = 7'd0;
            nxt[F_SEC] = 7'd0;
            fall_set   = 1'b1;
        end else if (cur[F_SEC] != 7'd59) begin
            nxt[F_SEC] = cur[F_SEC] + 7'd1;
        end else begin
            nxt[F_SEC] = 7'd0;
            if (cur[F_MIN] != 7'd59) begin
                nxt[F_MIN] = cur[F_MIN] + 7'd1;
            end else begin
                nxt[F_MIN] = 7'd0;
                if (cur[F_HOUR] != 7'd23) begin
                    nxt[F_HOUR] = cur[F_HOUR] + 7'd1;
                end else begin
                    nxt[F_HOUR] = 7'd0;
                    nxt[F_DOW]  = (cur[F_DOW] == 7'd7) ? 7'd1 : cur[F_DOW] + 7'd1;
                    if (cur[F_DOM] != month_days(cur[F_MON], cur[F_YEAR])) begin
                        nxt[F_DOM] = cur[F_DOM] + 7'd1;
                    end else begin
                        nxt[F_DOM] = 7'd1;
                        fall_clr   = 1'b1;
                        if (cur[F_MON] != 7'd12) begin
                            nxt[F_MON] = cur[F_MON] + 7'd1;
                        end else begin
                            nxt[F_MON]  = 7'd1;
                            nxt[F_YEAR] = (cur[F_YEAR] == 7'd99) ? 7'd0 : cur[F_YEAR] + 7'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= TOD_RESET;
            fell <= 1'b0;
        end else begin
            if (step) begin
                cur <= nxt;
                if (fall_set) fell <= 1'b1;
                if (fall_clr) fell <= 1'b0;
            end
            for (int i = 0; i < NFIELDS; i++)
                if (ld_mask[i]) cur[i] <= ld_val[i];
        end
    end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               xfer,
    input  logic               busy,
    input  tod_t               cur,
    output ctl_t               ctl,
    output logic [NFIELDS-1:0] ld_mask,
    output tod_t               ld_val
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [7:0]         bytes_q [DEPTH];
    logic [NFIELDS-1:0] dirty_q;
    logic [7:0]         enc_val [NFIELDS];
    logic               wr_ctl, reload;

    assign wr_ctl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign reload = wr_ctl && ctl.inh && !reg_wdata[7];

    always_comb begin
        for (int i = 0; i < NFIELDS; i++) begin
            logic       direct;
            logic [7:0] src;
            direct     = reg_wr && (reg_addr == field_addr(i)) && !ctl.inh;
            src        = direct ? reg_wdata : bytes_q[field_addr(i)];
            ld_val[i]  = (i == F_HOUR) ? dec_hour(src, ctl.bin, ctl.h24) : dec_byte(src, ctl.bin);
            ld_mask[i] = direct || (reload && dirty_q[i]);
            enc_val[i] = (i == F_HOUR) ? enc_hour(cur[i], ctl.bin, ctl.h24) : enc_byte(cur[i], ctl.bin);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) bytes_q[a] <= 8'h00;
            for (int i = 0; i < NFIELDS; i++)
                bytes_q[field_addr(i)] <= (i == F_HOUR) ? enc_hour(TOD_RESET[i], 1'b0, 1'b0)
                                                        : enc_byte(TOD_RESET[i], 1'b0);
            dirty_q <= '0;
            ctl     <= '0;
        end else begin
            if (xfer && !ctl.inh)
                for (int i = 0; i < NFIELDS; i++) bytes_q[field_addr(i)] <= enc_val[i];
            if (reg_wr && reg_addr < ADDR_W'(NBYTES))
                bytes_q[reg_addr] <= reg_wdata;
            if (reload) dirty_q <= '0;
            else
                for (int i = 0; i < NFIELDS; i++)
                    if (reg_wr && reg_addr == field_addr(i) && ctl.inh) dirty_q[i] <= 1'b1;
            if (wr_ctl)
                ctl <= '{inh: reg_wdata[7], uie: reg_wdata[4] & ~reg_wdata[7],
                         bin: reg_wdata[2], h24: reg_wdata[1], dst: reg_wdata[0]};
        end
    end

    always_comb begin
        if (reg_addr < ADDR_W'(NBYTES))            reg_rdata = bytes_q[reg_addr];
        else if (reg_addr == ADDR_W'(ADDR_STAT))   reg_rdata = {busy, 7'b0};
        else if (reg_addr == ADDR_W'(ADDR_CTRL))
            reg_rdata = {ctl.inh, 2'b00, ctl.uie, 1'b0, ctl.bin, ctl.h24, ctl.dst};
        else                                       reg_rdata = 8'h00;
    end
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
    import rtc_pkg::*;
#(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              upd_busy,
    output logic              upd_done,
    output logic              upd_irq
);
    ctl_t               ctl;
    tod_t               cur, ld_val;
    logic [NFIELDS-1:0] ld_mask;
    logic               step, xfer;

    rtc_update_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) i_seq (
        .clk(clk), .rst(rst), .tick(sec_tick), .inhibit(ctl.inh),
        .step(step), .xfer(xfer), .busy(upd_busy), .done(upd_done)
    );

    rtc_time_core i_core (
        .clk(clk), .rst(rst), .step(step), .dst_en(ctl.dst),
        .ld_mask(ld_mask), .ld_val(ld_val), .cur(cur)
    );

    rtc_host_regs i_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer(xfer),
        .busy(upd_busy), .cur(cur), .ctl(ctl), .ld_mask(ld_mask), .ld_val(ld_val)
    );

    assign upd_irq = upd_done && ctl.uie;
endmodule

// File: rtl/rtc_update_checker.sv
module rtc_update_checker
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              upd_busy,
    input logic              upd_done,
    input logic              upd_irq,
    input logic              inhibit,
    input logic              uie
);
    p_busy_from_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(upd_busy) && $past(!inhibit)) |-> $past(sec_tick));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        upd_done |=> !upd_done);

    p_done_busy_low_r3: assert property (@(posedge clk) disable iff (rst)
        upd_done |-> !upd_busy);

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_done && !inhibit && $past(!inhibit)) |-> $past(upd_busy));

    p_irq_needs_done_r3: assert property (@(posedge clk) disable iff (rst)
        upd_irq |-> upd_done);

    p_freeze_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(ADDR_CTRL) && reg_wdata[7]) |=> (!upd_busy && !uie));
endmodule

bind rtc_update_engine rtc_update_checker i_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .upd_busy(upd_busy),
    .upd_done(upd_done), .upd_irq(upd_irq), .inhibit(ctl.inh), .uie(ctl.uie)
);

// File: tb/test_rtc_update_engine.sv
module test_rtc_update_engine;
    localparam int L = 3;
    localparam int U = 5;

    logic       clk = 1'b0, rst = 1'b1, sec_tick = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       upd_busy, upd_done, upd_irq;

    int  checks = 0, errors = 0;
    int  rem = 0;
    bit  m_inh = 0, m_uie = 0, m_done = 0, finished = 0;

    always #5 clk = ~clk;

    rtc_update_engine #(.LEAD_CYC(L), .UPD_CYC(U)) i_rtc_update_engine (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .upd_busy(upd_busy), .upd_done(upd_done), .upd_irq(upd_irq)
    );

    // Behavioural timing model: remaining busy cycles and freeze/enable state.
    always @(posedge clk) begin
        bit start;
        if (rst) begin
            rem = 0; m_inh = 0; m_uie = 0; m_done = 0;
        end else begin
            start  = (rem == 0) && sec_tick;
            m_done = (rem == 1);
            if (rem > 0) rem = rem - 1;
            if (start) rem = L + U;
            if (reg_wr && reg_addr == 4'd11) begin
                m_inh = reg_wdata[7];
                m_uie = reg_wdata[4] && !reg_wdata[7];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit eb;
            eb = (rem > 0) && !m_inh;
            checks += 3;
            if (upd_busy !== eb) begin
                errors++;
                $display("FAIL R2 busy: actual %0b expected %0b at %0t", upd_busy, eb, $time);
            end
            if (upd_done !== m_done) begin
                errors++;
                $display("FAIL R3 done: actual %0b expected %0b at %0t", upd_done, m_done, $time);
            end
            if (upd_irq !== (m_done && m_uie)) begin
                errors++;
                $display("FAIL R3 irq: actual %0b expected %0b at %0t", upd_irq, m_done && m_uie, $time);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (L + U + 2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] c, input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dd,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(11, 8'h80 | c);
        wr(0, s); wr(2, m); wr(4, h); wr(6, dw); wr(7, dd); wr(8, mo); wr(9, yr);
        wr(11, c);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(0, 8'h00, "R1"); rd(4, 8'h12, "R1"); rd(6, 8'h01, "R1");
        rd(7, 8'h01, "R1"); rd(8, 8'h01, "R1"); rd(9, 8'h00, "R1");
        rd(11, 8'h00, "R1"); rd(10, 8'h00, "R1");

        // R4 full rollover, BCD 24-hour
        set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick();
        rd(0, 8'h00, "R4"); rd(2, 8'h00, "R4"); rd(4, 8'h00, "R4"); rd(6, 8'h01, "R4");
        rd(7, 8'h01, "R4"); rd(8, 8'h01, "R4"); rd(9, 8'h00, "R4");

        // R5 month lengths, R6 binary format
        set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h04);
        tick();
        rd(7, 8'h1D, "R5"); rd(8, 8'h02, "R5"); rd(6, 8'h04, "R4");
        set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1D, 8'h02, 8'h04);
        tick();
        rd(7, 8'h01, "R5"); rd(8, 8'h03, "R5");
        set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h01);
        tick();
        rd(7, 8'h01, "R5"); rd(8, 8'h03, "R5");
        set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1E, 8'h04, 8'h01);
        tick();
        rd(7, 8'h01, "R5"); rd(8, 8'h05, "R5");
        set_time(8'h06, 8'h1E, 8'h00, 8'h00, 8'h03, 8'h01, 8'h04, 8'h01);
        tick();
        rd(0, 8'h1F, "R6");

        // R7 12-hour mode
        set_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h05, 8'h21);
        tick(); rd(4, 8'h92, "R7");
        set_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h05, 8'h21);
        tick(); rd(4, 8'h81, "R7");
        set_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h05, 8'h21);
        tick(); rd(4, 8'h12, "R7");
        set_time(8'h04, 8'h3B, 8'h3B, 8'h0B, 8'h02, 8'h10, 8'h05, 8'h15);
        tick(); rd(4, 8'h8C, "R7");

        // R8 freeze, R9 deferred load, R2 ignored tick
        set_time(8'h02, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(11, 8'h92);
        rd(11, 8'h82, "R8");
        tick(); tick();
        rd(0, 8'h00, "R8");
        wr(11, 8'h12);
        rd(0, 8'h00, "R9");
        tick();
        rd(0, 8'h03, "R9");
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (2) @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (L + U + 2) @(negedge clk);
        rd(0, 8'h04, "R2");
        wr(11, 8'h82);
        wr(2, 8'h30);
        tick();
        wr(11, 8'h02);
        tick();
        rd(0, 8'h06, "R9"); rd(2, 8'h30, "R9"); rd(4, 8'h10, "R9");
        wr(0, 8'h20);
        rd(0, 8'h20, "R9");
        tick();
        rd(0, 8'h21, "R9");

        // R10 spring forward
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h21);
        tick(); rd(4, 8'h03, "R10"); rd(2, 8'h00, "R10"); rd(0, 8'h00, "R10");
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h02, 8'h02, 8'h04, 8'h21);
        tick(); rd(4, 8'h02, "R10");

        // R11 fall back once
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h21);
        tick(); rd(4, 8'h01, "R11"); rd(2, 8'h00, "R11"); rd(0, 8'h00, "R11");
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h21);
        tick(); rd(4, 8'h02, "R11");

        // R12 alarm bytes untouched
        wr(1, 8'h45); wr(3, 8'h12); wr(5, 8'hC0);
        tick();
        rd(1, 8'h45, "R12"); rd(3, 8'h12, "R12"); rd(5, 8'hC0, "R12");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule